// File: doc/BRIEF.md
# Digital Pulse-Stream Neuron

This block is a clocked neuron whose state is a single saturating activity register. Two one-bit pulse channels drive it. A high excitatory input in a cycle raises the activity by a small fixed packet. A high inhibitory input lowers it by a larger fixed packet. A run of inhibitory pulses therefore brings the neuron back to its silent state faster than excitation built it up.

The neuron signals its state as a rate of single-cycle output pulses, not as a level. A phase accumulator adds an increment each cycle and emits a pulse on every carry. The increment is a smooth, S-shaped, monotonic function of the activity. It is zero at zero activity and reaches a parameter-set maximum at full activity, so the firing rate rises gradually between the OFF and ON extremes. Downstream logic counts or gates the pulses. The activity value is also exported for observation.

Top module: `pulse_neuron`

## Requirements
- R1: An excitatory pulse (`exc_i`=1, `inh_i`=0) raises `activity_o` by EXC_PKT (default 4), visible at the first clock edge that samples it.
- R2: An inhibitory pulse (`inh_i`=1, `exc_i`=0) lowers `activity_o` by INH_PKT (default 8), visible at the first clock edge that samples it.
- R3: When both inputs are high in the same cycle, `activity_o` changes once by the net amount EXC_PKT minus INH_PKT (default −4), subject to R4 and R5.
- R4: `activity_o` saturates at 2^ACT_W−1 (default 255) and never wraps to a small value.
- R5: `activity_o` saturates at 0 and never wraps to a large value.
- R6: While `activity_o` has been 0 in the previous cycle, `fire_o` is 0.
- R7: At full activity the increment equals RATE_MAX (default 512 of a 2^ACC_W = 1024 phase range), so `fire_o` pulses exactly every second cycle.
- R8: Each cycle the accumulator adds inc(a) = floor(RATE_MAX·(3·M·a² − 2·a³)/M³), where a is the current `activity_o` and M = 2^ACT_W−1. `fire_o` goes high in the cycle after the addition that carries past 2^ACC_W. For a fixed activity, more activity never gives fewer pulses.
- R9: `fire_o` is never high in two consecutive cycles.
- R10: A cycle with `rst`=1 clears the activity, the accumulator and `fire_o` at that edge. Reset is synchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_i | input | 1 | Excitatory pulse, one packet per high cycle |
| inh_i | input | 1 | Inhibitory pulse, one packet per high cycle |
| fire_o | output | 1 | Output pulse stream, single-cycle pulses |
| activity_o | output | ACT_W | Current activity value |

## Verification
The hardest condition to reach is an exact pulse phase at a chosen intermediate activity. The accumulator keeps its residue across changes in activity, so every pulse depends on the whole history since reset. The bench runs a cycle-accurate reference of the integrator and accumulator, clears both through reset, and climbs to levels 64, 128 and 192 by counted excitatory pulses. It then compares every output cycle and checks that the pulse counts increase with level. Saturation at both ends is forced by input trains longer than the range, including cycles where both inputs are high.

// File: rtl/pulse_neuron_pkg.sv
package pulse_neuron_pkg;

  // Smooth S-shaped increment: rmax * (3*m*a^2 - 2*a^3) / m^3
  function automatic longint smooth_rate(longint a, longint m, longint rmax);
    longint num;
    num = 3 * m * a * a - 2 * a * a * a;
    return (rmax * num) / (m * m * m);
  endfunction

  // Saturating activity update with both packets applied as one net change
  function automatic int step_activity(int a, bit up, bit dn, int up_pkt,
                                       int dn_pkt, int amax);
    int n;
    n = a + (up ? up_pkt : 0) - (dn ? dn_pkt : 0);
    if (n < 0) n = 0;
    if (n > amax) n = amax;
    return n;
  endfunction

endpackage

// File: rtl/neuron_integrator.sv
module neuron_integrator
  import pulse_neuron_pkg::*;
#(
  parameter int ACT_W   = 8,
  parameter int EXC_PKT = 4,
  parameter int INH_PKT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_i,
  input  logic             inh_i,
  output logic [ACT_W-1:0] act_o
);
  localparam int AMAX = (1 << ACT_W) - 1;

  logic [ACT_W-1:0] act_q;
  logic [ACT_W-1:0] act_d;

  always_comb begin
    act_d = ACT_W'(step_activity(int'(act_q), exc_i, inh_i, EXC_PKT, INH_PKT, AMAX));
  end

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= act_d;
  end

  assign act_o = act_q;
endmodule

// File: rtl/neuron_rate_map.sv
module neuron_rate_map
  import pulse_neuron_pkg::*;
#(
  parameter int ACT_W    = 8,
  parameter int ACC_W    = 10,
  parameter int RATE_MAX = 512
) (
  input  logic [ACT_W-1:0] act_i,
  output logic [ACC_W:0]   inc_o
);
  localparam int NLEV = 1 << ACT_W;
  localparam int AMAX = NLEV - 1;

  logic [ACC_W:0] lut [NLEV];

  for (genvar k = 0; k < NLEV; k++) begin : g_lut
    assign lut[k] = (ACC_W+1)'(smooth_rate(longint'(k), longint'(AMAX), longint'(RATE_MAX)));
  end

  assign inc_o = lut[act_i];
endmodule

// File: rtl/neuron_phase_osc.sv
module neuron_phase_osc #(
  parameter int ACC_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [ACC_W:0] inc_i,
  output logic           wrap_o,
  output logic           fire_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W+1:0] sum;

  assign sum    = {2'b00, acc_q} + {1'b0, inc_i};
  assign wrap_o = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      fire_o <= 1'b0;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      fire_o <= wrap_o;
    end
  end
endmodule

// File: rtl/pulse_neuron.sv
module pulse_neuron #(
  parameter int ACT_W    = 8,
  parameter int ACC_W    = 10,
  parameter int EXC_PKT  = 4,
  parameter int INH_PKT  = 8,
  parameter int RATE_MAX = 512
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             exc_i,
  input  logic             inh_i,
  output logic             fire_o,
  output logic [ACT_W-1:0] activity_o
);
  // Pulses stay single-cycle only while the top increment is at most half the phase range
  initial begin
    if (RATE_MAX > (1 << (ACC_W - 1)))
      $error("RATE_MAX must not exceed half the phase range");
  end

  logic [ACT_W-1:0] act_w;
  logic [ACC_W:0]   inc_w;
  logic             wrap_w;

  neuron_integrator #(.ACT_W(ACT_W), .EXC_PKT(EXC_PKT), .INH_PKT(INH_PKT)) u_integ (
    .clk(clk), .rst(rst), .exc_i(exc_i), .inh_i(inh_i), .act_o(act_w)
  );

  neuron_rate_map #(.ACT_W(ACT_W), .ACC_W(ACC_W), .RATE_MAX(RATE_MAX)) u_map (
    .act_i(act_w), .inc_o(inc_w)
  );

  neuron_phase_osc #(.ACC_W(ACC_W)) u_osc (
    .clk(clk), .rst(rst), .inc_i(inc_w), .wrap_o(wrap_w), .fire_o(fire_o)
  );

  assign activity_o = act_w;
endmodule

// File: rtl/pulse_neuron_chk.sv
module pulse_neuron_chk #(
  parameter int ACT_W    = 8,
  parameter int ACC_W    = 10,
  parameter int EXC_PKT  = 4,
  parameter int INH_PKT  = 8,
  parameter int RATE_MAX = 512
) (
  input logic             clk,
  input logic             rst,
  input logic             exc_i,
  input logic             inh_i,
  input logic             fire_o,
  input logic [ACT_W-1:0] activity_o,
  input logic [ACC_W:0]   inc_w,
  input logic             wrap_w
);
  localparam logic [ACT_W-1:0] AMAX = {ACT_W{1'b1}};

  // R1
  exc_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (exc_i && !inh_i) |=> (activity_o >= $past(activity_o)));

  // R2
  inh_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (inh_i && !exc_i) |=> (activity_o <= $past(activity_o)));

  // R4
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (activity_o == AMAX && exc_i && !inh_i) |=> (activity_o == AMAX));

  // R5
  floor_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (activity_o == '0 && inh_i && !exc_i) |=> (activity_o == '0));

  // R6
  silent_chk: assert property (@(posedge clk) disable iff (rst)
    (activity_o == '0) |=> !fire_o);

  // R8
  fire_follows_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_w |=> fire_o);

  // R8
  inc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_w <= (ACC_W+1)'(RATE_MAX)));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !fire_o);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (activity_o == '0 && !fire_o));
endmodule

bind pulse_neuron pulse_neuron_chk #(
  .ACT_W(ACT_W), .ACC_W(ACC_W), .EXC_PKT(EXC_PKT), .INH_PKT(INH_PKT), .RATE_MAX(RATE_MAX)
) u_chk (
  .clk(clk), .rst(rst), .exc_i(exc_i), .inh_i(inh_i), .fire_o(fire_o),
  .activity_o(activity_o), .inc_w(inc_w), .wrap_w(wrap_w)
);

// File: tb/pulse_neuron_tb.sv
module pulse_neuron_tb;
  localparam int ACT_W = 8, ACC_W = 10, EP = 4, IP = 8, RMAX = 512;
  localparam int M = (1 << ACT_W) - 1;
  localparam int PH = 1 << ACC_W;

  logic clk = 1'b0, rst = 1'b1, exc = 1'b0, inh = 1'b0;
  logic fire;
  logic [ACT_W-1:0] act;

  int checks = 0, errors = 0;
  int m_act = 0, m_acc = 0, m_fire = 0;
  int mism_act, mism_fire, pulses;
  bit done = 0;

  pulse_neuron u_dut (.clk(clk), .rst(rst), .exc_i(exc), .inh_i(inh),
                      .fire_o(fire), .activity_o(act));

  always #10 clk = ~clk;

  // {exc, inh, cycles, expected activity, requirement}
  localparam int VEC [7][5] = '{
    '{1, 0, 10,  40, 1},
    '{1, 1,  3,  28, 3},
    '{0, 1,  2,  12, 2},
    '{0, 1,  2,   0, 5},
    '{1, 0, 70, 255, 4},
    '{0, 0,  5, 255, 7},
    '{1, 1,  5, 235, 3}
  };

  function automatic int ref_inc(int a);
    longint t;
    t = longint'(a) * a * (3 * M) - 2 * longint'(a) * a * a;
    return int'((t * RMAX) / (longint'(M) * M * M));
  endfunction

  function automatic string rname(int r);
    case (r)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      5: return "R5"; 7: return "R7"; default: return "R8";
    endcase
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  // One clock with inputs driven on the falling edge; model updated after the rising edge
  task automatic step(bit e, bit i, bit r);
    int s;
    @(negedge clk);
    exc = e; inh = i; rst = r;
    @(posedge clk);
    #1;
    if (r) begin
      m_act = 0; m_acc = 0; m_fire = 0;
    end else begin
      s = m_acc + ref_inc(m_act);
      m_fire = (s >= PH) ? 1 : 0;
      m_acc = s % PH;
      m_act = m_act + (e ? EP : 0) - (i ? IP : 0);
      if (m_act < 0) m_act = 0;
      if (m_act > M) m_act = M;
    end
    if (int'(act) != m_act) mism_act++;
    if (int'(fire) != m_fire) mism_fire++;
    if (fire) pulses++;
  endtask

  task automatic clear_counts();
    mism_act = 0; mism_fire = 0; pulses = 0;
  endtask

  initial begin
    int lvl_cnt [3];
    int prev_fire;
    int dbl;

    // R10: reset state
    clear_counts();
    repeat (3) step(0, 0, 1);
    check("R10 reset activity", int'(act), 0);
    check("R10 reset fire", int'(fire), 0);

    // Table walk
    for (int v = 0; v < 7; v++) begin
      clear_counts();
      for (int c = 0; c < VEC[v][2]; c++) step(VEC[v][0][0], VEC[v][1][0], 0);
      check({rname(VEC[v][4]), " activity"}, int'(act), VEC[v][3]);
      check({rname(VEC[v][4]), " cycle trace"}, mism_act + mism_fire, 0);
    end

    // R7: full activity fires every second cycle
    step(0, 0, 1);
    clear_counts();
    for (int c = 0; c < 64; c++) step(1, 0, 0);
    clear_counts();
    for (int c = 0; c < 100; c++) step(0, 0, 0);
    check("R7 pulses at full activity", pulses, 50);
    check("R7 trace", mism_fire, 0);

    // R6: zero activity stays silent
    for (int c = 0; c < 40; c++) step(0, 1, 0);
    step(0, 0, 0);
    clear_counts();
    for (int c = 0; c < 200; c++) step(0, 0, 0);
    check("R6 pulses at zero activity", pulses, 0);

    // R8: mid levels, exact trace and monotonic counts
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 1);
      for (int c = 0; c < 16 * (k + 1); c++) step(1, 0, 0);
      clear_counts();
      for (int c = 0; c < 256; c++) step(0, 0, 0);
      lvl_cnt[k] = pulses;
      check("R8 level trace", mism_act + mism_fire, 0);
    end
    check("R8 count 64 vs 128", int'(lvl_cnt[1] > lvl_cnt[0]), 1);
    check("R8 count 128 vs 192", int'(lvl_cnt[2] > lvl_cnt[1]), 1);
    check("R8 count at 64", lvl_cnt[0], (256 * ref_inc(64)) / PH);

    // R9: no back-to-back pulses across a sweep
    step(0, 0, 1);
    dbl = 0; prev_fire = 0;
    for (int c = 0; c < 400; c++) begin
      step(c < 70, 0, 0);
      if (fire && prev_fire) dbl++;
      prev_fire = int'(fire);
    end
    check("R9 consecutive pulses", dbl, 0);

    // R10: mid-run reset clears activity and phase
    for (int c = 0; c < 20; c++) step(1, 0, 0);
    step(1, 0, 1);
    check("R10 mid-run activity", int'(act), 0);
    check("R10 mid-run fire", int'(fire), 0);
    clear_counts();
    for (int c = 0; c < 30; c++) step(1, 0, 0);
    for (int c = 0; c < 60; c++) step(0, 0, 0);
    check("R10 phase restart trace", mism_act + mism_fire, 0);

    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule